// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

This block turns general-purpose pin levels into per-line interrupt and event requests. It has sixteen lines. Each line watches one pin, and the line's 4-bit source field picks which port that pin comes from. The controller brings every port pin into the clock domain through two flip-flops. It then picks the level for each line and compares it with the level from one cycle before to find rising and falling edges.

An edge that matches a line's trigger enables does two things:
- When the interrupt mask is set, it raises a sticky pending flag. The flag drives that line's interrupt request.
- When the event mask is set, it fires a one-cycle event pulse. The pulse never touches the pending flags.

Software can also raise pending flags by writing to a trigger register. It clears them by writing ones. When a line's source field is rewritten, the edge history for that line is refreshed, so the change of source itself never counts as an edge.

Top module: `exti_line_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and `irq` and `evt` are zero.
- R2: Line n follows bit p*16+n of `port_pins`. Here p is the 4-bit source field for line n, held at bits [4*(n%4)+3 : 4*(n%4)] of source register n/4 (addresses 0 to 3). A field value of 7 or more gives a constant low level. Pins of ports that a line does not select have no effect on it.
- R3: A low-to-high change on a line whose rising enable (address 6) and interrupt mask (address 4) bits are set sets its pending bit.
- R4: A high-to-low change on a line whose falling enable (address 7) and interrupt mask bits are set sets its pending bit. A change in a direction that is not enabled sets nothing.
- R5: A line whose interrupt mask bit is clear never gains a pending bit, either from an edge or from the software trigger.
- R6: A detected edge on a line whose event mask bit (address 5) is set gives exactly one `evt` pulse of one cycle on that line. The pulse does not change the pending register.
- R7: Writing 1 to a bit of the pending register (address 9) clears that bit. Writing 0 leaves it unchanged.
- R8: Writing 1 to a bit of the software trigger register (address 8, reads as zero) sets that line's pending bit when its interrupt mask bit is set.
- R9: Rewriting a line's source field never produces an edge, even when the old and new source pins differ in level. Edges on the new source are detected afterwards.
- R10: `irq` always equals the pending register.
- R11: A pin change applied between clock edges becomes visible in `irq` and `evt` right after the third rising clock edge. `evt` falls again after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins | input | 112 | Raw pin levels, port p pin n at bit p*16+n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 16 | Per-line interrupt requests (pending flags) |
| evt | output | 16 | Per-line one-cycle event pulses |

## Verification
The assertions assume that register writes are single-cycle strobes with a stable address. They also assume the design is free to choose what happens when a set and a clear of the same pending bit land in the same cycle, because they only check that a bit never drops without a clearing write. The stimulus changes pins only at falling clock edges. It holds every pin long enough for the two-stage synchroniser to settle before trigger enables are turned on. It also never combines a software trigger with a pending clear in the same write. These limits keep every observed edge attributable to one deliberate pin change.

// File: rtl/exti_line_ctrl.sv
module exti_line_ctrl #(
  parameter int NLINES = 16,
  parameter int NPORTS = 7,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLINES-1:0] port_pins,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NLINES-1:0]        wdata,
  output logic [NLINES-1:0]        rdata,
  output logic [NLINES-1:0]        irq,
  output logic [NLINES-1:0]        evt
);
  localparam int NSELREG = (NLINES * SEL_W) / NLINES;
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(NSELREG);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(NSELREG + 1);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(NSELREG + 2);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(NSELREG + 3);
  localparam logic [ADDR_W-1:0] A_SWTRG = ADDR_W'(NSELREG + 4);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(NSELREG + 5);

  logic [NPORTS*NLINES-1:0] sync1, sync2;
  logic [NLINES*SEL_W-1:0]  sel_q, sel_last;
  logic [NLINES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, evt_q, prev_q;
  logic [NLINES-1:0] cur, sel_chg, hit, sw_set, clr;

  genvar n;
  generate
    for (n = 0; n < NLINES; n++) begin : g_line
      logic lvl;
      always_comb begin
        lvl = 1'b0;
        for (int p = 0; p < NPORTS; p++)
          if (sel_q[n*SEL_W +: SEL_W] == SEL_W'(p)) lvl = sync2[p*NLINES + n];
      end
      assign cur[n]     = lvl;
      assign sel_chg[n] = sel_q[n*SEL_W +: SEL_W] != sel_last[n*SEL_W +: SEL_W];
    end
  endgenerate

  assign hit    = ((cur & ~prev_q & rise_q) | (~cur & prev_q & fall_q)) & ~sel_chg;
  assign sw_set = (wr_en && addr == A_SWTRG) ? wdata : '0;
  assign clr    = (wr_en && addr == A_PEND)  ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      prev_q   <= '0;
      sel_last <= '0;
      pend_q   <= '0;
      evt_q    <= '0;
    end else begin
      sync1    <= port_pins;
      sync2    <= sync1;
      prev_q   <= cur;
      sel_last <= sel_q;
      pend_q   <= (pend_q & ~clr) | ((hit | sw_set) & imask_q);
      evt_q    <= hit & emask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NSELREG; r++)
        if (addr == ADDR_W'(r)) sel_q[r*NLINES +: NLINES] <= wdata;
      if (addr == A_IMASK) imask_q <= wdata;
      if (addr == A_EMASK) emask_q <= wdata;
      if (addr == A_RISE)  rise_q  <= wdata;
      if (addr == A_FALL)  fall_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NSELREG; r++)
      if (addr == ADDR_W'(r)) rdata = sel_q[r*NLINES +: NLINES];
    case (addr)
      A_IMASK: rdata = imask_q;
      A_EMASK: rdata = emask_q;
      A_RISE:  rdata = rise_q;
      A_FALL:  rdata = fall_q;
      A_PEND:  rdata = pend_q;
      default: ;
    endcase
  end

  assign irq = pend_q;
  assign evt = evt_q;
endmodule

module exti_line_ctrl_chk #(
  parameter int NLINES = 16,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_PEND = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [NLINES-1:0]       wdata,
  input logic [NLINES-1:0]       irq,
  input logic [NLINES-1:0]       evt,
  input logic [NLINES-1:0]       imask_q,
  input logic [NLINES-1:0]       emask_q,
  input logic [NLINES*SEL_W-1:0] sel_q
);
  logic [NLINES*SEL_W-1:0] sel_d;
  logic [NLINES-1:0] clr_d, chg_now, chg_d;

  always_comb
    for (int i = 0; i < NLINES; i++)
      chg_now[i] = sel_q[i*SEL_W +: SEL_W] != sel_d[i*SEL_W +: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= '0;
      clr_d <= '0;
      chg_d <= '0;
    end else begin
      sel_d <= sel_q;
      clr_d <= (wr_en && addr == A_PEND) ? wdata : '0;
      chg_d <= chg_now;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0 && evt == '0));

  assert_pend_only_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq) & ~clr_d) == '0));

  assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq) & ~$past(imask_q)) == '0));

  assert_evt_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(emask_q)) == '0));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & chg_d) == '0));
endmodule

bind exti_line_ctrl exti_line_ctrl_chk #(
  .NLINES(NLINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .A_PEND(A_PEND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .evt(evt), .imask_q(imask_q), .emask_q(emask_q), .sel_q(sel_q)
);

// File: tb/sim_exti_line_ctrl.sv
module sim_exti_line_ctrl;
  localparam int NL = 16;
  localparam int NP = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP*NL-1:0] pins = '0;
  logic wr_en = 0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, irq, evt;
  int checks = 0, fails = 0, ev_total = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exti_line_ctrl u0 (.clk(clk), .rst_n(rst_n), .port_pins(pins), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .evt(evt));

  always @(negedge clk) ev_total += $countones(evt);

  // {line, port, rise, fall, dir(1=up), exp_pend, imask, emask, exp_evt, 0}
  localparam logic [15:0] TV [0:7] = '{16'h00B8, 16'h5358, 16'hF6DE, 16'h7188,
                                       16'h92A6, 16'hC558, 16'h34A0, 16'hE05E};

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int a = 0; a < 8; a++) if (a != 8) wr(4'(a), 16'h0);
    wr(4'd9, 16'hFFFF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 16'h0);
    end
    chk("R1 irq after reset", irq, 16'h0);
    chk("R1 evt after reset", evt, 16'h0);

    // R3 R4 R5 R6 R10 table walk
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      int ln, pt, base;
      e = TV[i];
      ln = int'(e[15:12]); pt = int'(e[11:8]);
      pins = '0;
      pins[pt*NL + ln] = ~e[5];
      cyc(4);
      wr(4'(ln/4), 16'(int'(pt) << (4*(ln%4))));
      cyc(4);
      wr(4'd9, 16'hFFFF);
      wr(4'd4, 16'(e[3]) << ln);
      wr(4'd5, 16'(e[2]) << ln);
      wr(4'd6, 16'(e[7]) << ln);
      wr(4'd7, 16'(e[6]) << ln);
      base = ev_total;
      pins[pt*NL + ln] = e[5];
      cyc(6);
      rd(4'd9, v);
      chk($sformatf("R3 R4 R5 pending row %0d", i), v, 16'(e[4]) << ln);
      chk($sformatf("R10 irq row %0d", i), irq, 16'(e[4]) << ln);
      chk($sformatf("R6 evt pulses row %0d", i), 16'(ev_total - base), 16'(e[1]));
      wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0); wr(4'd3, 0);
      clear_all();
    end

    // R8 R5 software trigger
    pins = '0; cyc(4);
    wr(4'd8, 16'h0014);
    rd(4'd9, v);
    chk("R5 swtrig without mask", v, 16'h0);
    rd(4'd8, v);
    chk("R8 swtrig reads zero", v, 16'h0);
    wr(4'd4, 16'h0014);
    wr(4'd8, 16'h0014);
    rd(4'd9, v);
    chk("R8 swtrig sets pending", v, 16'h0014);
    // R7 W1C
    wr(4'd9, 16'h0000);
    rd(4'd9, v);
    chk("R7 write zero keeps pending", v, 16'h0014);
    wr(4'd9, 16'h0004);
    rd(4'd9, v);
    chk("R7 write one clears bit", v, 16'h0010);
    chk("R10 irq follows pending", irq, 16'h0010);
    clear_all();

    // R9 selector change, R2 source choice
    pins = '0;
    pins[2*NL + 1] = 1'b1;
    cyc(4);
    wr(4'd4, 16'h0002); wr(4'd5, 16'h0002);
    wr(4'd6, 16'h0002); wr(4'd7, 16'h0002);
    base_chk: begin
      int b0;
      b0 = ev_total;
      wr(4'd0, 16'h0020);
      cyc(6);
      rd(4'd9, v);
      chk("R9 no pending on source change", v, 16'h0);
      chk("R9 no event on source change", 16'(ev_total - b0), 16'h0);
      pins[0*NL + 1] = 1'b1;
      cyc(6);
      rd(4'd9, v);
      chk("R2 unselected port ignored", v, 16'h0);
      pins[2*NL + 1] = 1'b0;
      cyc(6);
      rd(4'd9, v);
      chk("R9 new source edge seen", v, 16'h0002);
    end
    clear_all();

    // R2 out-of-range source field
    pins = '0; cyc(4);
    wr(4'd1, 16'h0009);
    wr(4'd4, 16'h0010); wr(4'd6, 16'h0010); wr(4'd7, 16'h0010);
    pins = '1;
    cyc(6);
    rd(4'd9, v);
    chk("R2 field 9 stays low", v, 16'h0);
    wr(4'd1, 16'h0000);
    clear_all();

    // R11 latency
    pins = '0; cyc(4);
    wr(4'd1, 16'h0100);
    wr(4'd4, 16'h0040); wr(4'd5, 16'h0040); wr(4'd6, 16'h0040);
    cyc(2);
    pins[1*NL + 6] = 1'b1;
    cyc(2);
    chk("R11 irq not yet after two edges", irq, 16'h0);
    chk("R11 evt not yet after two edges", evt, 16'h0);
    cyc(1);
    chk("R11 irq after third edge", irq, 16'h0040);
    chk("R11 evt after third edge", evt, 16'h0040);
    cyc(1);
    chk("R11 evt drops after fourth edge", evt, 16'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule